// File: doc/BRIEF.md
# Recovered-Clock Lock Detector

This block watches a recovered line clock and decides whether it can be trusted as the receive clock. It compares the recovered clock against a local reference clock and reports the result. The reference side cuts time into fixed measurement windows of 2048 reference cycles. Edges of the recovered clock are counted in their own clock domain over each window. Each count crosses into the reference domain through a toggle handshake and is checked against a tolerance band of about 0.5 %.

A separate activity monitor reports whether the recovered clock is toggling at all. The control state machine uses both indications. It raises a loss-of-lock flag after one bad window, or at once when activity stops. It clears the flag only after two good windows in a row.

A registered clock-select output follows the lock state, and it changes only at window boundaries. While in training, the select picks the reference clock. While in recovery, it picks the recovered clock. The clock multiplexer itself, the analog loop and the line decoder sit outside this block.

Top module: `rclk_lock_mon`

## Requirements
- R1: While reset (`rstN` low) is applied and right after it is released, `lossOfLock` is 1 and `clkSel` is 0.
- R2: If no recovered-clock edge reaches the block for 256 reference cycles, `lossOfLock` goes to 1 within a few cycles after that. A recovered clock that was running until 200 reference cycles ago does not cause loss of lock on this ground.
- R3: A measurement window lasts 2048 reference cycles. A window is good when its recovered-clock edge count lies from 2038 to 2058, both limits included. A recovered period of 5.02 ns or 4.98 ns against a 5 ns reference counts as good. A period of 5.035 ns or 4.97 ns counts as bad.
- R4: `lossOfLock` falls to 0 only after two consecutive good windows while the line is active. A single good window that follows a bad one leaves `lossOfLock` at 1.
- R5: One bad window sets `lossOfLock` to 1 once that window's count has been evaluated, a few cycles after the window closes.
- R6: `clkSel` changes only at a window boundary. At that boundary it loads the inverse of `lossOfLock` as it stands there. A value of 1 selects the recovered clock.
- R7: While the block is in training (`lossOfLock` is 1), `clkSel` becomes 0 at the next window boundary and stays 0, so the reference clock is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Local reference clock; the measurement and control domain |
| recClk | input | 1 | Recovered line clock under test |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| lossOfLock | output | 1 | 1 while training (lock lost), 0 while in recovery |
| clkSel | output | 1 | Registered receive-clock select: 0 reference, 1 recovered |

## Verification
A wrong window counter, a band limit that is off by a few counts, or a lock-run counter in the wrong state changes which window boundary moves `lossOfLock` and `clkSel`. The bench aligns its stimulus to the boundaries it sees on `clkSel`, so any such error shows within one or two windows, about 2048 to 4096 reference cycles. A stuck activity timer shows within roughly 300 cycles after the recovered clock stops. A select that updates away from a boundary, or that skips the training value, shows as a wrong `clkSel` sampled 60 cycles after the boundary.

// File: rtl/rclk_lock_pkg.sv
package rclk_lock_pkg;

  // Strobes and flags handed from the measurement datapath to the control.
  typedef struct packed {
    logic windowEnd;   // last reference cycle of a measurement window
    logic countValid;  // a fresh recovered-clock count has arrived
    logic inRange;     // that count lies inside the tolerance band
    logic lineActive;  // recovered clock seen toggling recently
  } measStrb_t;

endpackage

// File: rtl/rclk_sync2.sv
module rclk_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/rclk_rec_counter.sv
module rclk_rec_counter #(
  parameter int CNT_W   = 13,
  parameter int ACT_BIT = 2
) (
  input  logic             recClk,
  input  logic             rstN,
  input  logic             reqTog,
  output logic [CNT_W-1:0] holdCnt,
  output logic             ackTog,
  output logic             actTog
);

  localparam int DIV_W = ACT_BIT + 1;

  logic             reqSync;
  logic             reqSeen;
  logic [CNT_W-1:0] edgeCnt;
  logic [DIV_W-1:0] divCnt;
  logic             reqEdge;

  rclk_sync2 #(.WIDTH(1)) uReqSync (
    .clk (recClk),
    .rstN(rstN),
    .d   (reqTog),
    .q   (reqSync)
  );

  assign reqEdge = reqSync ^ reqSeen;

  // Edge counter: the capturing edge starts the next span, so every
  // recovered edge lands in exactly one span.
  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      holdCnt <= '0;
      ackTog  <= 1'b0;
      reqSeen <= 1'b0;
    end else if (reqEdge) begin
      holdCnt <= edgeCnt;
      edgeCnt <= CNT_W'(1);
      ackTog  <= ~ackTog;
      reqSeen <= reqSync;
    end else if (edgeCnt != '1) begin
      edgeCnt <= edgeCnt + CNT_W'(1);
    end
  end

  // Slow activity toggle, safe to sample in the reference domain.
  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + DIV_W'(1);
  end

  assign actTog = divCnt[ACT_BIT];

endmodule

// File: rtl/rclk_lock_datapath.sv
module rclk_lock_datapath
  import rclk_lock_pkg::*;
#(
  parameter int WIN_LEN  = 2048,
  parameter int TOL      = 10,
  parameter int IDLE_LIM = 256,
  parameter int ACT_BIT  = 2
) (
  input  logic      refClk,
  input  logic      recClk,
  input  logic      rstN,
  output measStrb_t strb
);

  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int CNT_W  = $clog2(2 * WIN_LEN) + 1;
  localparam int IDLE_W = $clog2(IDLE_LIM + 1);
  localparam int LO_LIM = WIN_LEN - TOL;
  localparam int HI_LIM = WIN_LEN + TOL;

  logic [WIN_W-1:0]  winCnt;
  logic              windowEnd;
  logic              reqTog;
  logic              ackSync;
  logic              ackSeen;
  logic              countValid;
  logic [CNT_W-1:0]  holdCnt;
  logic              ackTog;
  logic              actTog;
  logic              actSync;
  logic              actPrev;
  logic [IDLE_W-1:0] idleCnt;
  logic              lineActive;

  rclk_rec_counter #(.CNT_W(CNT_W), .ACT_BIT(ACT_BIT)) uRecCnt (
    .recClk (recClk),
    .rstN   (rstN),
    .reqTog (reqTog),
    .holdCnt(holdCnt),
    .ackTog (ackTog),
    .actTog (actTog)
  );

  rclk_sync2 #(.WIDTH(2)) uBackSync (
    .clk (refClk),
    .rstN(rstN),
    .d   ({ackTog, actTog}),
    .q   ({ackSync, actSync})
  );

  // Measurement window in the reference domain.
  assign windowEnd = (winCnt == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)          winCnt <= '0;
    else if (windowEnd) winCnt <= '0;
    else                winCnt <= winCnt + WIN_W'(1);
  end

  // Request a new count only when the previous one has come back;
  // otherwise the window is skipped and the next span runs long.
  assign countValid = ackSync ^ ackSeen;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      reqTog  <= 1'b0;
      ackSeen <= 1'b0;
    end else begin
      if (windowEnd && (reqTog == ackSeen)) reqTog <= ~reqTog;
      if (countValid)                       ackSeen <= ackSync;
    end
  end

  // Line activity: any change of the slow toggle restarts the idle timer.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      actPrev <= 1'b0;
      idleCnt <= IDLE_W'(IDLE_LIM);
    end else begin
      actPrev <= actSync;
      if (actSync != actPrev)               idleCnt <= '0;
      else if (idleCnt < IDLE_W'(IDLE_LIM)) idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

  assign lineActive = (idleCnt < IDLE_W'(IDLE_LIM));

  assign strb.windowEnd  = windowEnd;
  assign strb.countValid = countValid;
  assign strb.inRange    = (holdCnt >= CNT_W'(LO_LIM)) && (holdCnt <= CNT_W'(HI_LIM));
  assign strb.lineActive = lineActive;

  p_idle_bound_r2: assert property (@(posedge refClk) disable iff (!rstN)
    idleCnt <= IDLE_W'(IDLE_LIM));

  p_window_gap_r3: assert property (@(posedge refClk) disable iff (!rstN)
    windowEnd |=> !windowEnd);

  p_valid_once_r3: assert property (@(posedge refClk) disable iff (!rstN)
    countValid |=> !countValid);

endmodule

// File: rtl/rclk_lock_ctrl.sv
module rclk_lock_ctrl
  import rclk_lock_pkg::*;
#(
  parameter int LOCK_WINS = 2
) (
  input  logic      refClk,
  input  logic      rstN,
  input  measStrb_t strb,
  output logic      lossOfLock,
  output logic      clkSel
);

  localparam int RUN_W = $clog2(LOCK_WINS + 1);

  logic [RUN_W-1:0] goodRun;

  // Training / recovery decision.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      lossOfLock <= 1'b1;
      goodRun    <= '0;
    end else if (!strb.lineActive) begin
      lossOfLock <= 1'b1;
      goodRun    <= '0;
    end else if (strb.countValid) begin
      if (strb.inRange) begin
        if (goodRun >= RUN_W'(LOCK_WINS - 1)) begin
          lossOfLock <= 1'b0;
          goodRun    <= RUN_W'(LOCK_WINS);
        end else begin
          goodRun <= goodRun + RUN_W'(1);
        end
      end else begin
        lossOfLock <= 1'b1;
        goodRun    <= '0;
      end
    end
  end

  // Receive clock select moves only on window boundaries.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)               clkSel <= 1'b0;
    else if (strb.windowEnd) clkSel <= ~lossOfLock;
  end

  p_idle_lol_r2: assert property (@(posedge refClk) disable iff (!rstN)
    !strb.lineActive |=> lossOfLock);

  p_unlock_good_r4: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lossOfLock) |-> $past(strb.countValid && strb.inRange && strb.lineActive));

  p_bad_window_r5: assert property (@(posedge refClk) disable iff (!rstN)
    (strb.countValid && !strb.inRange) |=> lossOfLock);

  p_sel_boundary_r6: assert property (@(posedge refClk) disable iff (!rstN)
    !strb.windowEnd |=> $stable(clkSel));

  p_sel_training_r7: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(clkSel) |-> $past(!lossOfLock));

endmodule

// File: rtl/rclk_lock_mon.sv
module rclk_lock_mon
  import rclk_lock_pkg::*;
#(
  parameter int WIN_LEN   = 2048,
  parameter int TOL       = 10,
  parameter int IDLE_LIM  = 256,
  parameter int LOCK_WINS = 2,
  parameter int ACT_BIT   = 2
) (
  input  logic refClk,
  input  logic recClk,
  input  logic rstN,
  output logic lossOfLock,
  output logic clkSel
);

  measStrb_t strb;

  rclk_lock_datapath #(
    .WIN_LEN (WIN_LEN),
    .TOL     (TOL),
    .IDLE_LIM(IDLE_LIM),
    .ACT_BIT (ACT_BIT)
  ) uDp (
    .refClk(refClk),
    .recClk(recClk),
    .rstN  (rstN),
    .strb  (strb)
  );

  rclk_lock_ctrl #(.LOCK_WINS(LOCK_WINS)) uCtrl (
    .refClk    (refClk),
    .rstN      (rstN),
    .strb      (strb),
    .lossOfLock(lossOfLock),
    .clkSel    (clkSel)
  );

endmodule

// File: tb/sim_rclk_lock_mon.sv
`timescale 1ns/1ps
module sim_rclk_lock_mon;

  localparam int W = 2048;

  logic refClk = 1'b0;
  logic recClk = 1'b0;
  logic rstN   = 1'b0;
  logic lossOfLock;
  logic clkSel;

  logic recRun  = 1'b1;
  real  recHalf = 2.5;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic  lol;
    logic  sel;
    bit    useLol;
    bit    useSel;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  rclk_lock_mon u0 (
    .refClk    (refClk),
    .recClk    (recClk),
    .rstN      (rstN),
    .lossOfLock(lossOfLock),
    .clkSel    (clkSel)
  );

  initial forever #2.5 refClk = ~refClk;

  initial forever begin
    if (recRun) #(recHalf) recClk = ~recClk;
    else        #1;
  end

  task automatic waitRef(input int n);
    repeat (n) @(posedge refClk);
  endtask

  task automatic pushExp(input logic lol, input logic sel,
                         input bit useLol, input bit useSel, input string tag);
    expItem_t it;
    it.lol = lol; it.sel = sel; it.useLol = useLol; it.useSel = useSel; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: pops expectations and compares away from the active edge.
  initial forever begin
    @(negedge refClk);
    while (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      nChecks++;
      if ((it.useLol && lossOfLock !== it.lol) || (it.useSel && clkSel !== it.sel)) begin
        nFails++;
        $display("FAIL %s: lossOfLock=%b (exp %b) clkSel=%b (exp %b)",
                 it.tag, lossOfLock, it.lol, clkSel, it.sel);
      end
    end
  end

  // Step: stimulus at boundary+5, check at boundary+60, return at next boundary+5.
  task automatic step(input real half, input logic lol, input logic sel,
                      input bit useLol, input bit useSel, input string tag);
    recHalf = half;
    waitRef(55);
    pushExp(lol, sel, useLol, useSel, tag);
    waitRef(W - 55);
  endtask

  initial begin
    bit seen;
    logic prevSel;
    waitRef(10);
    pushExp(1'b1, 1'b0, 1, 1, "R1 during reset");
    waitRef(2);
    rstN = 1'b1;
    waitRef(20);
    pushExp(1'b1, 1'b0, 1, 1, "R1 after reset / R7 training select");

    waitRef(5 * W);
    pushExp(1'b0, 1'b1, 1, 1, "R4/R6 locked on matching clock");

    recRun = 1'b0;
    waitRef(200);
    pushExp(1'b0, 1'b0, 1, 0, "R2 not yet idle at 200 cycles");
    waitRef(100);
    pushExp(1'b1, 1'b0, 1, 0, "R2 idle loss after 256 cycles");
    waitRef(W + 10);
    pushExp(1'b1, 1'b0, 1, 1, "R7 reference selected in training");

    recRun = 1'b1;
    recHalf = 2.5;
    waitRef(5 * W);
    pushExp(1'b0, 1'b1, 1, 1, "R4 relock after restart");

    // Slow clock; wait for clkSel to fall to find a window boundary.
    recHalf = 2.55;
    prevSel = clkSel;
    seen = 1'b0;
    for (int i = 0; i < 4 * W && !seen; i++) begin
      @(negedge refClk);
      if (clkSel !== prevSel) seen = 1'b1;
    end
    nChecks++;
    if (!seen) begin
      nFails++;
      $display("FAIL R6 clkSel never fell: clkSel=%b (exp 0)", clkSel);
    end
    waitRef(5);

    step(2.5,    1'b1, 1'b0, 1, 1, "R5 slow window gives loss");
    step(2.5,    1'b1, 1'b0, 1, 0, "R4 one good window not enough");
    step(2.55,   1'b0, 1'b0, 1, 1, "R4 lock after two / R6 select waits");
    step(2.51,   1'b1, 1'b1, 1, 1, "R5 single bad window / R6 select at boundary");
    step(2.51,   1'b1, 1'b0, 1, 1, "R7 select back to reference");
    step(2.485,  1'b0, 1'b0, 1, 1, "R3 period 5.02 in band");
    step(2.5175, 1'b1, 1'b1, 1, 1, "R3 period 4.97 out of band");
    step(2.49,   1'b1, 1'b0, 1, 1, "R3 period 5.035 out of band");
    step(2.49,   1'b1, 1'b0, 1, 0, "R4 first 4.98 window");
    step(2.55,   1'b0, 1'b0, 1, 0, "R3 period 4.98 in band");
    step(2.5,    1'b1, 1'b1, 1, 1, "R5 bad window after lock");
    step(2.55,   1'b1, 1'b0, 1, 1, "R4 good then bad, no lock");
    step(2.5,    1'b1, 1'b0, 1, 0, "R4 alternating windows stay unlocked");

    waitRef(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    waitRef(190000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete (exp completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule